// File: doc/BRIEF.md
# Interrupt Level Priority Resolver

This block merges two kinds of interrupt sources into a single pending request for the processor. One source is a 4-bit encoded level bus with inverted coding: the all-zero code is the most urgent level, and the all-ones code means that nothing is pending. The other source is sixteen level-sensitive pin interrupts. These pins are split into a low group (pins 0-7) and a high group (pins 8-15). Each group has one programmable 4-bit priority.

Each cycle the block finds the highest pending level among the encoded bus and the two pin groups. It registers that level together with a source identifier. It also compares the winner against the processor's current 4-bit mask level. A separate registered wake output reports when a pending pin group is above the mask, which the standby logic can use. The processor acknowledges a request with an accept strobe. The block never changes the mask, and it keeps no memory of past requests: a source that is deasserted simply disappears.

Top module: `irq_level_resolver`

## Requirements
- R1: An encoded bus value c in 0..14 presents level 15-c with source id 1. The value 15 (all ones) presents no request from that bus.
- R2: When any pin of a group is high, that group presents its programmed priority as its level. The source id is 2 for pins 0-7 and 3 for pins 8-15.
- R3: req_valid is 1 exactly when the resolved level is strictly greater than the mask level sampled on the same edge. req_level shows the highest pending level even when req_valid is 0, and it shows 0 with source id 0 when nothing is pending.
- R4: On equal levels the encoded bus beats both pin groups, and pins 0-7 beat pins 8-15.
- R5: Reset clears both group priorities and all outputs. Until a priority is written, a group's pins produce level 0 and never a request or a wake.
- R6: A write (prio_wr_en=1) loads prio_wr_data[3:0] as the pins 0-7 priority and prio_wr_data[7:4] as the pins 8-15 priority. The new values take effect from the following edge.
- R7: req_level, req_src and req_valid reflect the inputs sampled at the previous rising edge.
- R8: On an edge where accept is 1, req_valid, req_level and req_src keep their values.
- R9: wake is registered and is 1 exactly when some group with at least one high pin has a priority strictly greater than the mask level. The encoded bus does not drive wake, and accept does not freeze it.
- R10: Pins are level-sensitive. Once a pin drops, its request is gone on the next update, and no edge is latched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enc_req_n | input | 4 | Inverted encoded level request (15 = none) |
| pin_irq | input | 16 | Level-sensitive pin interrupts |
| prio_wr_en | input | 1 | Group priority write strobe |
| prio_wr_data | input | 8 | [3:0] pins 0-7 priority, [7:4] pins 8-15 priority |
| mask_lvl | input | 4 | Processor mask level |
| accept | input | 1 | Processor accepts the current request |
| req_valid | output | 1 | Resolved level is above the mask |
| req_level | output | 4 | Resolved highest pending level |
| req_src | output | 2 | 0 none, 1 encoded bus, 2 pins 0-7, 3 pins 8-15 |
| wake | output | 1 | Pending pin group above the mask |

## Verification
The bench targets the ends of the inverted code. A decoder that is not inverted would report level 0 for code 0 and a level for code 15. It also drives ties between the encoded bus and the two groups, at equal levels. A design with the wrong tie-break comparison would name the wrong source. For mask equality it sets the mask equal to the winning level, where a design using a non-strict compare would raise req_valid. Other cases: an accept cycle while the inputs change, which catches outputs that fail to hold; pins that drop right after they assert, which catches any latching; and pins asserted before any priority is written, which would leak requests or wake if the reset value were wrong.

// File: rtl/irq_res_pkg.sv
package irq_res_pkg;
  localparam int LVL_W        = 4;
  localparam int SRC_NONE     = 0;
  localparam int SRC_ENC      = 1;
  localparam int SRC_GRP_BASE = 2;
endpackage

// File: rtl/irq_enc_decode.sv
module irq_enc_decode
  import irq_res_pkg::*;
(
  input  logic [LVL_W-1:0] code_n,
  output logic [LVL_W-1:0] lvl
);
  // inverted code: all zeros is the top level, all ones decodes to level 0 (none)
  always_comb begin
    lvl = ~code_n;
  end
endmodule

// File: rtl/irq_grp_prio_reg.sv
module irq_grp_prio_reg
  import irq_res_pkg::*;
#(
  parameter int NUM_GROUPS = 2
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        wr_en,
  input  logic [NUM_GROUPS*LVL_W-1:0] wr_data,
  output logic [NUM_GROUPS*LVL_W-1:0] prio_q
);
  logic [NUM_GROUPS*LVL_W-1:0] prio_d;

  always_comb begin
    prio_d = wr_en ? wr_data : prio_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prio_q <= '0;
    else        prio_q <= prio_d;
  end

  // R5
  prio_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(prio_q));
endmodule

// File: rtl/irq_pin_group.sv
module irq_pin_group
  import irq_res_pkg::*;
#(
  parameter int GROUP_SIZE = 8
) (
  input  logic [GROUP_SIZE-1:0] pins,
  input  logic [LVL_W-1:0]      prio,
  output logic [LVL_W-1:0]      lvl
);
  always_comb begin
    lvl = (|pins) ? prio : '0;
  end
endmodule

// File: rtl/irq_level_resolver.sv
module irq_level_resolver
  import irq_res_pkg::*;
#(
  parameter int NUM_PINS   = 16,
  parameter int GROUP_SIZE = 8
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic [LVL_W-1:0]                     enc_req_n,
  input  logic [NUM_PINS-1:0]                  pin_irq,
  input  logic                                 prio_wr_en,
  input  logic [(NUM_PINS/GROUP_SIZE)*LVL_W-1:0] prio_wr_data,
  input  logic [LVL_W-1:0]                     mask_lvl,
  input  logic                                 accept,
  output logic                                 req_valid,
  output logic [LVL_W-1:0]                     req_level,
  output logic [$clog2(NUM_PINS/GROUP_SIZE+2)-1:0] req_src,
  output logic                                 wake
);
  localparam int NUM_GROUPS = NUM_PINS / GROUP_SIZE;
  localparam int SRC_W      = $clog2(NUM_GROUPS + 2);

  logic [LVL_W-1:0]            enc_lvl;
  logic [NUM_GROUPS*LVL_W-1:0] prio_q;
  logic [LVL_W-1:0]            grp_lvl [NUM_GROUPS];

  logic [LVL_W-1:0] best_lvl;
  logic [SRC_W-1:0] best_src;
  logic             best_valid;
  logic             wake_d;
  logic             hold_en;

  irq_enc_decode u_dec (
    .code_n (enc_req_n),
    .lvl    (enc_lvl)
  );

  irq_grp_prio_reg #(.NUM_GROUPS(NUM_GROUPS)) u_prio (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (prio_wr_en),
    .wr_data (prio_wr_data),
    .prio_q  (prio_q)
  );

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
    irq_pin_group #(.GROUP_SIZE(GROUP_SIZE)) u_grp (
      .pins (pin_irq[g*GROUP_SIZE +: GROUP_SIZE]),
      .prio (prio_q[g*LVL_W +: LVL_W]),
      .lvl  (grp_lvl[g])
    );
  end

  // winner select: candidates in tie-break order, replaced only on strictly higher level
  always_comb begin
    best_lvl = enc_lvl;
    best_src = (enc_lvl != '0) ? SRC_W'(SRC_ENC) : SRC_W'(SRC_NONE);
    wake_d   = 1'b0;
    for (int g = 0; g < NUM_GROUPS; g++) begin
      if (grp_lvl[g] > best_lvl) begin
        best_lvl = grp_lvl[g];
        best_src = SRC_W'(SRC_GRP_BASE + g);
      end
      if (grp_lvl[g] > mask_lvl) wake_d = 1'b1;
    end
    best_valid = best_lvl > mask_lvl;
    hold_en    = !accept;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_valid <= 1'b0;
      req_level <= '0;
      req_src   <= '0;
    end else if (hold_en) begin
      req_valid <= best_valid;
      req_level <= best_lvl;
      req_src   <= best_src;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wake <= 1'b0;
    else        wake <= wake_d;
  end

  // R8
  accept_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> $stable({req_valid, req_level, req_src}));
  // R1
  enc_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!accept && enc_req_n == '0) |=> (req_level == '1 && req_src == SRC_W'(SRC_ENC)));
  // R3
  valid_above_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !accept |=> (req_valid == (req_level > $past(mask_lvl))));
  // R4
  valid_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> (req_src != SRC_W'(SRC_NONE)));
  // R9
  wake_no_pin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_irq == '0) |=> !wake);
endmodule

// File: tb/irq_level_resolver_bench.sv
module irq_level_resolver_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [3:0]  enc_req_n;
  logic [15:0] pin_irq;
  logic        prio_wr_en;
  logic [7:0]  prio_wr_data;
  logic [3:0]  mask_lvl;
  logic        accept;
  logic        req_valid;
  logic [3:0]  req_level;
  logic [1:0]  req_src;
  logic        wake;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  logic [7:0] m_prio;
  logic       e_valid;
  logic [3:0] e_level;
  logic [1:0] e_src;
  logic       e_wake;

  always #10 clk = ~clk;

  irq_level_resolver u_irq_level_resolver (
    .clk(clk), .rst_n(rst_n), .enc_req_n(enc_req_n), .pin_irq(pin_irq),
    .prio_wr_en(prio_wr_en), .prio_wr_data(prio_wr_data), .mask_lvl(mask_lvl),
    .accept(accept), .req_valid(req_valid), .req_level(req_level),
    .req_src(req_src), .wake(wake)
  );

  // reference model from the requirements: returns {valid, level, src, wake}
  function automatic logic [7:0] model(input logic [3:0] enc, input logic [15:0] pins,
                                       input logic [7:0] prio, input logic [3:0] mask);
    logic [3:0] l0, l1, best;
    logic [1:0] src;
    logic       wk;
    best = (enc == 4'hF) ? 4'd0 : 4'd15 - enc;
    src  = (best != 0) ? 2'd1 : 2'd0;
    l0 = (|pins[7:0])  ? prio[3:0] : 4'd0;
    l1 = (|pins[15:8]) ? prio[7:4] : 4'd0;
    if (l0 > best) begin best = l0; src = 2'd2; end
    if (l1 > best) begin best = l1; src = 2'd3; end
    wk = (l0 > mask) || (l1 > mask);
    return {(best > mask), best, src, wk};
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // drive one cycle of inputs at negedge, check registered outputs at next negedge
  task automatic step(input logic [3:0] enc, input logic [15:0] pins, input logic we,
                      input logic [7:0] wd, input logic [3:0] mask, input logic acc,
                      input string tag);
    logic [7:0] r;
    enc_req_n = enc; pin_irq = pins; prio_wr_en = we; prio_wr_data = wd;
    mask_lvl = mask; accept = acc;
    r = model(enc, pins, m_prio, mask);
    if (!acc) begin e_valid = r[7]; e_level = r[6:3]; e_src = r[2:1]; end
    e_wake = r[0];
    if (we) m_prio = wd;
    @(negedge clk);
    chk(tag, req_valid, e_valid, "req_valid");
    chk(tag, req_level, e_level, "req_level");
    chk(tag, req_src,   e_src,   "req_src");
    chk(tag, wake,      e_wake,  "wake");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1234_5678));
    rst_n = 1'b0; enc_req_n = 4'hF; pin_irq = '0; prio_wr_en = 0;
    prio_wr_data = '0; mask_lvl = '0; accept = 0;
    m_prio = '0; e_valid = 0; e_level = 0; e_src = 0; e_wake = 0;
    repeat (3) @(negedge clk);
    // R5 reset state
    chk("R5", {req_valid, req_level, req_src, wake}, 8'h00, "reset outputs");
    rst_n = 1'b1;
    @(negedge clk);
    // R5 pins before any priority write stay silent
    step(4'hF, 16'hFFFF, 0, 8'h00, 4'd0, 0, "R5");
    // R1 every encoded value
    for (int c = 0; c < 16; c++) step(c[3:0], 16'h0000, 0, 8'h00, 4'd0, 0, "R1");
    // R6 program priorities: low group 10, high group 5
    step(4'hF, 16'h0000, 1, 8'h5A, 4'd0, 0, "R6");
    step(4'hF, 16'h0001, 0, 8'h00, 4'd0, 0, "R6");
    step(4'hF, 16'h0100, 0, 8'h00, 4'd0, 0, "R2");
    step(4'hF, 16'h8080, 0, 8'h00, 4'd0, 0, "R2");
    // R10 pin drop clears request
    step(4'hF, 16'h0000, 0, 8'h00, 4'd0, 0, "R10");
    // R3 mask equality and one below
    step(4'hF, 16'h0010, 0, 8'h00, 4'd10, 0, "R3");
    step(4'hF, 16'h0010, 0, 8'h00, 4'd9, 0, "R3");
    // R9 wake ignores encoded bus
    step(4'h0, 16'h0000, 0, 8'h00, 4'd3, 0, "R9");
    step(4'hF, 16'h0200, 0, 8'h00, 4'd4, 0, "R9");
    // R4 ties at level 7
    step(4'hF, 16'h0000, 1, 8'h77, 4'd0, 0, "R6");
    step(4'd8, 16'h0101, 0, 8'h00, 4'd0, 0, "R4");
    step(4'hF, 16'h0101, 0, 8'h00, 4'd0, 0, "R4");
    // R8 accept holds while inputs change, wake still follows
    step(4'd2, 16'h0000, 0, 8'h00, 4'd0, 0, "R8");
    step(4'hF, 16'h0100, 0, 8'h00, 4'd0, 1, "R8");
    step(4'hF, 16'h0100, 0, 8'h00, 4'd0, 0, "R8");
    // random traffic, R7 latency
    for (int i = 0; i < 3000; i++) begin
      logic [15:0] p;
      p = ($urandom % 3 == 0) ? 16'h0 : 16'($urandom) & (16'h1 << ($urandom % 16));
      step(4'($urandom), p, ($urandom % 16 == 0), 8'($urandom), 4'($urandom),
           ($urandom % 5 == 0), "R7");
    end
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule